// File: doc/BRIEF.md
# Ping-pong sample output demultiplexer

This block is the digital back end of a pipelined 8-bit sampler. On every rising edge of the encode clock it captures one sample from a plain parallel input and carries it through a fixed-depth pipeline to one of two output ports. With the mode pin high, every result lands on port A and port B stays frozen. With the mode pin low, results alternate between A and B, so each port refreshes at half the encode rate and a receiver can work at half speed.

A divide-by-two phase state machine decides which port the next captured sample goes to. It has two states. `SLOT_A` tags the current capture for port A and always moves to `SLOT_B`. `SLOT_B` has two exits. On a plain toggle it tags the capture for B and returns to `SLOT_A`. On a conflicting sync it tags the capture for A and stays in `SLOT_B`. A sync falling edge that arrives in `SLOT_A` is an agreeing sync and takes the plain toggle path, so it has no effect.

After reset the phase is whatever the `PHASE_INIT` parameter says, standing in for an unknown power-up phase. A falling edge on the sync input sets the phase. From that edge on, the sample captured on the edge itself, and every second one after it, goes to port A. A conflicting sync marks one in-flight sample on each port as invalid. Each port has a one-cycle valid strobe.

Top module: `pingpong_demux`

## Requirements
- R1: While `rst_n` is low, `a_data` and `b_data` read 0 and `a_vld` and `b_vld` are low.
- R2: With `single_mode` high (single-port mode), the sample on `smp_in` at capture edge k appears on `a_data` with `a_vld` high right after edge k+4.
- R3: In single-port mode `b_vld` stays low and `b_data` does not change.
- R4: With `single_mode` low (dual-port mode), the sample captured at edge k appears right after edge k+5, on exactly one port. Successive samples use alternate ports, so a port's strobe is never high on two consecutive cycles.
- R5: With no sync since reset, capture edge 0 goes to port A when `PHASE_INIT` is 0 and to port B when it is 1.
- R6: A sync event is `sync_in` sampled high at one edge and low at the next. In dual-port mode, the sample captured at the sync edge goes to port A and the following sample goes to port B.
- R7: A sync event that finds the phase already aimed at port A changes no output data and no strobe. A sync pulse train at half the encode rate may therefore run continuously.
- R8: In dual-port mode, a sync event that finds the phase aimed at port B marks two samples invalid: the one captured one edge earlier, delivered on A, and the one captured two edges earlier, delivered on B. Both are delivered with their strobe low. Later samples are valid.
- R9: A strobe is high only in the cycle right after its port takes in a valid sample. Both strobes stay low for the first 4 (single-port) or 5 (dual-port) edges after reset.
- R10: In single-port mode, sync events have no effect on port A data or strobe.
- R11: In dual-port mode, a port keeps its last data while the other port is being updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encode clock; a sample is captured on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| single_mode | input | 1 | High selects single-port mode; low selects dual-port mode |
| sync_in | input | 1 | Phase sync; a high-to-low change between two edges is a sync event |
| smp_in | input | 8 | Sample word captured on each rising edge |
| a_data | output | 8 | Port A sample |
| a_vld | output | 1 | Port A took in a valid sample on the last edge |
| b_data | output | 8 | Port B sample |
| b_vld | output | 1 | Port B took in a valid sample on the last edge |

## Verification
The properties assume that `single_mode` changes only while `rst_n` is low. They also assume `smp_in` is driven with known values from the first edge after reset, since the single-port latency check compares `a_data` with the input five edges earlier. The stimulus meets both assumptions. The mode is set inside each reset window, and sample and sync values are driven on the falling clock edge, drawn from a fixed-seed random stream or a directed pattern. Directed sequences place sync events in both phases, including a continuous half-rate pulse train, so that both agreeing and conflicting syncs occur.

// File: rtl/pp_pkg.sv
`timescale 1ns/1ps
package pp_pkg;
    // Port a captured sample is steered to in dual-port mode
    typedef enum logic {
        SLOT_A = 1'b0,
        SLOT_B = 1'b1
    } slot_e;
endpackage

// File: rtl/pp_sync_detect.sv
`timescale 1ns/1ps
module pp_sync_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic fall_o
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= sync_i;
    end

    // high at the edge where sync is low after being high one edge before
    assign fall_o = seen_q & ~sync_i;
endmodule

// File: rtl/pp_phase_fsm.sv
`timescale 1ns/1ps
module pp_phase_fsm
    import pp_pkg::*;
#(
    parameter bit PHASE_INIT = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  dual_i,
    input  logic  fall_i,
    output slot_e tag_o,
    output logic  kill_o
);
    localparam slot_e RESET_SLOT = PHASE_INIT ? SLOT_B : SLOT_A;

    slot_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RESET_SLOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        tag_o   = SLOT_A;
        kill_o  = 1'b0;
        unique case (state_q)
            SLOT_A: begin
                // plain toggle; an agreeing sync lands here too
                tag_o   = SLOT_A;
                state_d = SLOT_B;
            end
            SLOT_B: begin
                if (fall_i) begin
                    // conflicting sync: realign onto port A
                    tag_o   = SLOT_A;
                    kill_o  = dual_i;
                    state_d = SLOT_B;
                end else begin
                    tag_o   = SLOT_B;
                    state_d = SLOT_A;
                end
            end
        endcase
    end
endmodule

// File: rtl/pp_pipe.sv
`timescale 1ns/1ps
module pp_pipe
    import pp_pkg::*;
#(
    parameter int W         = 8,
    parameter int DEPTH     = 5,
    parameter int SHORT_TAP = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         single_i,
    input  logic [W-1:0] d_i,
    input  slot_e        tag_i,
    input  logic         kill_i,
    output logic [W-1:0] d_o,
    output slot_e        tag_o,
    output logic         ok_o
);
    localparam int LONG_TAP = DEPTH - 1;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        logic [W-1:0] d_q;
        slot_e        t_q;
        logic         ok_q;

        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    d_q  <= '0;
                    t_q  <= SLOT_A;
                    ok_q <= 1'b0;
                end else begin
                    d_q  <= d_i;
                    t_q  <= tag_i;
                    ok_q <= 1'b1;
                end
            end
        end else begin : g_body
            // stages 1 and 2 receive the two samples a conflicting sync spoils
            localparam bit SPOIL = (g == 1) || (g == 2);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    d_q  <= '0;
                    t_q  <= SLOT_A;
                    ok_q <= 1'b0;
                end else begin
                    d_q  <= g_stage[g-1].d_q;
                    t_q  <= g_stage[g-1].t_q;
                    ok_q <= g_stage[g-1].ok_q & ~(kill_i & SPOIL);
                end
            end
        end
    end

    assign d_o   = single_i ? g_stage[SHORT_TAP].d_q  : g_stage[LONG_TAP].d_q;
    assign tag_o = single_i ? g_stage[SHORT_TAP].t_q  : g_stage[LONG_TAP].t_q;
    assign ok_o  = single_i ? g_stage[SHORT_TAP].ok_q : g_stage[LONG_TAP].ok_q;
endmodule

// File: rtl/pp_port_out.sv
`timescale 1ns/1ps
module pp_port_out
    import pp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         single_i,
    input  logic [W-1:0] d_i,
    input  slot_e        tag_i,
    input  logic         ok_i,
    output logic [W-1:0] a_data,
    output logic         a_vld,
    output logic [W-1:0] b_data,
    output logic         b_vld
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_data <= '0;
            a_vld  <= 1'b0;
            b_data <= '0;
            b_vld  <= 1'b0;
        end else if (single_i || tag_i == SLOT_A) begin
            a_data <= d_i;
            a_vld  <= ok_i;
            b_vld  <= 1'b0;
        end else begin
            b_data <= d_i;
            b_vld  <= ok_i;
            a_vld  <= 1'b0;
        end
    end
endmodule

// File: rtl/pingpong_demux.sv
`timescale 1ns/1ps
module pingpong_demux
    import pp_pkg::*;
#(
    parameter int W          = 8,
    parameter int LAT_SINGLE = 4,
    parameter int LAT_DUAL   = 5,
    parameter bit PHASE_INIT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         single_mode,
    input  logic         sync_in,
    input  logic [W-1:0] smp_in,
    output logic [W-1:0] a_data,
    output logic         a_vld,
    output logic [W-1:0] b_data,
    output logic         b_vld
);
    localparam int DEPTH     = LAT_DUAL;
    localparam int SHORT_TAP = LAT_SINGLE - 1;

    logic         fall;
    logic         kill;
    slot_e        cap_tag;
    logic [W-1:0] tap_d;
    slot_e        tap_tag;
    logic         tap_ok;

    pp_sync_detect u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_in),
        .fall_o (fall)
    );

    pp_phase_fsm #(.PHASE_INIT(PHASE_INIT)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .dual_i (~single_mode),
        .fall_i (fall),
        .tag_o  (cap_tag),
        .kill_o (kill)
    );

    pp_pipe #(.W(W), .DEPTH(DEPTH), .SHORT_TAP(SHORT_TAP)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .single_i (single_mode),
        .d_i      (smp_in),
        .tag_i    (cap_tag),
        .kill_i   (kill),
        .d_o      (tap_d),
        .tag_o    (tap_tag),
        .ok_o     (tap_ok)
    );

    pp_port_out #(.W(W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .single_i (single_mode),
        .d_i      (tap_d),
        .tag_i    (tap_tag),
        .ok_i     (tap_ok),
        .a_data   (a_data),
        .a_vld    (a_vld),
        .b_data   (b_data),
        .b_vld    (b_vld)
    );
endmodule

// File: rtl/pingpong_demux_chk.sv
`timescale 1ns/1ps
module pingpong_demux_chk #(
    parameter int W          = 8,
    parameter int LAT_SINGLE = 4,
    parameter int LAT_DUAL   = 5
) (
    input logic         clk,
    input logic         rst_n,
    input logic         single_mode,
    input logic [W-1:0] smp_in,
    input logic [W-1:0] a_data,
    input logic         a_vld,
    input logic [W-1:0] b_data,
    input logic         b_vld
);
    int edges;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          edges <= 0;
        else if (edges < 15) edges <= edges + 1;
    end

    assert_fill_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (edges <= (single_mode ? LAT_SINGLE : LAT_DUAL)) |-> (!a_vld && !b_vld));

    assert_single_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (single_mode && edges > LAT_SINGLE) |->
            (a_vld && a_data == $past(smp_in, LAT_SINGLE + 1)));

    assert_b_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        single_mode |-> !b_vld);

    assert_b_static_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (single_mode && $past(single_mode)) |-> $stable(b_data));

    assert_one_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !single_mode |-> !(a_vld && b_vld));

    assert_a_alternate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_mode && a_vld) |=> !a_vld);

    assert_b_alternate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_mode && b_vld) |=> !b_vld);
endmodule

bind pingpong_demux pingpong_demux_chk #(
    .W(W), .LAT_SINGLE(LAT_SINGLE), .LAT_DUAL(LAT_DUAL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .single_mode (single_mode),
    .smp_in      (smp_in),
    .a_data      (a_data),
    .a_vld       (a_vld),
    .b_data      (b_data),
    .b_vld       (b_vld)
);

// File: tb/sim_pingpong_demux.sv
`timescale 1ns/1ps
module sim_pingpong_demux;
    localparam int  LS = 4;
    localparam int  LD = 5;
    localparam bit  PH0 = 1'b1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       single_mode = 1'b1;
    logic       sync_in = 1'b0;
    logic [7:0] smp_in = 8'h00;
    logic [7:0] a_data, b_data;
    logic       a_vld, b_vld;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pingpong_demux #(.W(8), .LAT_SINGLE(LS), .LAT_DUAL(LD), .PHASE_INIT(PH0)) u0 (
        .clk(clk), .rst_n(rst_n), .single_mode(single_mode), .sync_in(sync_in),
        .smp_in(smp_in), .a_data(a_data), .a_vld(a_vld), .b_data(b_data), .b_vld(b_vld)
    );

    // behavioural model built from the requirements
    logic [7:0] hd [0:2047];
    bit         ht [0:2047];
    bit         hk [0:2047];
    int         m_n;
    bit         m_prev, m_ph;
    logic [7:0] e_a, e_b;
    bit         e_av, e_bv;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_n = 0; m_prev = 1'b0; m_ph = PH0;
            e_a = 8'h00; e_b = 8'h00; e_av = 1'b0; e_bv = 1'b0;
        end else begin
            bit fall, tag, clash;
            int j;
            fall   = m_prev & ~sync_in;
            m_prev = sync_in;
            clash  = fall && m_ph && !single_mode;
            tag    = fall ? 1'b0 : m_ph;
            m_ph   = ~tag;
            if (m_n < 2048) begin
                hd[m_n] = smp_in; ht[m_n] = tag; hk[m_n] = 1'b1;
                if (clash && m_n >= 1) hk[m_n-1] = 1'b0;
                if (clash && m_n >= 2) hk[m_n-2] = 1'b0;
            end
            j = m_n - (single_mode ? LS : LD);
            e_av = 1'b0; e_bv = 1'b0;
            if (j < 0) begin
                e_a = 8'h00;
            end else if (single_mode || !ht[j]) begin
                e_a = hd[j]; e_av = hk[j];
            end else begin
                e_b = hd[j]; e_bv = hk[j];
            end
            m_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int got, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic cmp_model(input string req);
        chk(a_data == e_a, req, "a_data", a_data, e_a);
        chk(a_vld == e_av, req, "a_vld", a_vld, e_av);
        chk(b_data == e_b, req, "b_data", b_data, e_b);
        chk(b_vld == e_bv, req, "b_vld", b_vld, e_bv);
    endtask

    // drive inputs for the next edge, then compare after that edge
    task automatic step(input logic [7:0] d, input logic s, input string req);
        smp_in  = d;
        sync_in = s;
        @(negedge clk);
        cmp_model(req);
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0; single_mode = mode; sync_in = 1'b0;
        @(negedge clk);
        chk(a_data == 8'h00 && b_data == 8'h00, "R1", "reset data", {a_data, b_data}, 0);
        chk(!a_vld && !b_vld, "R1", "reset strobes", {a_vld, b_vld}, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] dv [0:63];
        logic       s;
        void'($urandom(32'd1234));

        // single-port mode with random sync activity (R2 R3 R9 R10)
        do_reset(1'b1);
        for (int i = 0; i < 300; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            if (i < 64) dv[i] = d;
            step(d, 1'($urandom % 3 == 0), "R2 R3 R10");
            if (i == 3) chk(!a_vld, "R9", "a_vld in fill", a_vld, 0);
            if (i == 4) chk(a_vld && a_data == dv[0], "R9", "first a", a_data, dv[0]);
            if (i == 8) chk(a_data == dv[4], "R2", "a_data lat4", a_data, dv[4]);
        end
        chk(!b_vld && b_data == 8'h00, "R3", "port B frozen", b_data, 0);

        // dual-port mode, directed conflicting then agreeing sync (R4 R5 R6 R7 R8 R11)
        do_reset(1'b0);
        for (int i = 0; i < 60; i++) begin
            dv[i] = 8'($urandom);
            s = (i == 9 || i == 11);
            step(dv[i], s, "R4 R11");
            if (i == 4)  chk(!a_vld && !b_vld, "R9", "dual fill", {a_vld, b_vld}, 0);
            if (i == 5)  chk(b_vld && b_data == dv[0], "R5", "first on B", b_data, dv[0]);
            if (i == 13) chk(!b_vld && b_data == dv[8], "R8", "spoiled B", b_vld, 0);
            if (i == 14) chk(!a_vld && a_data == dv[9], "R8", "spoiled A", a_vld, 0);
            if (i == 15) chk(a_vld && a_data == dv[10], "R6", "sync sample on A", a_data, dv[10]);
            if (i == 16) chk(b_vld && b_data == dv[11], "R6", "next on B", b_data, dv[11]);
            if (i == 17) chk(a_vld && a_data == dv[12], "R7", "agreeing sync", a_data, dv[12]);
            if (i == 18) chk(!a_vld && a_data == dv[12], "R11", "A holds", a_data, dv[12]);
        end

        // dual-port mode, random sync events (R6 R7 R8)
        do_reset(1'b0);
        for (int i = 0; i < 400; i++)
            step(8'($urandom), 1'($urandom % 5 == 0), "R6 R7 R8");

        // dual-port mode, continuous half-rate sync train (R7)
        do_reset(1'b0);
        for (int i = 0; i < 200; i++) begin
            step(8'($urandom), 1'(i % 2), "R7");
            if (i > 20) chk(a_vld ^ b_vld, "R7", "one port each cycle", {a_vld, b_vld}, 1);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule